// File: doc/BRIEF.md
# Dual-Role Port Event and Status Register Unit

This unit is the register front end of a dual-role USB port. It brings the connector ID level and the B-session-valid level into the bus clock domain through a two-flop synchronizer and reports both as live status bits. Every change of either synchronized level, rising or falling, latches a sticky event bit. Software acknowledges an event by writing a one to it. An enable register selects which latched events raise the level interrupt, and that interrupt is registered.

The unit also holds a small configuration register and a control register. Two control bits drive the peripheral-mode and port-power outputs. A read-only capability register announces that dual-role support is present. The bus is a single-cycle port: a write commits on the clock edge that samples the write strobe, and read data follows the address combinationally in the same cycle.

Top module: `otg_regs`

## Requirements
- R1: Status register (offset 0x10) bit 0 shows the synchronized connector ID level and bit 2 shows the synchronized B-session-valid level. A change on an input is visible after the second rising clock edge and not after the first. All other status bits read 0.
- R2: Any change of the synchronized ID level, rising or falling, sets event register (offset 0x08) bit 24 on the third rising edge after the input changes.
- R3: Any change of the synchronized B-session-valid level, rising or falling, sets event bit 8 on the third rising edge after the input changes.
- R4: Writing 1 to event bit 24 or bit 8 clears it, and writing 0 leaves it unchanged. Event bit 31 always reads the current peripheral-mode control bit, and even an all-ones write does not clear it. All other event bits read 0.
- R5: When an event sets on the same edge that a write-1 clear of that bit commits, the bit stays set.
- R6: The event-enable register (offset 0x0C) has writable bits 24 and 8 and reads 0 elsewhere. irq_o rises one edge after the AND of the event and enable registers becomes nonzero, and falls one edge after it becomes zero. With the enable register at 0, irq_o stays low.
- R7: The control register (offset 0x04) has read/write bits 6..0 and resets to 0x40. Bit 6 drives peri_mode_o and bit 5 drives port_pwr_o. Bits 31..7 read 0.
- R8: The configuration register (offset 0x00) has read/write bits 2..0, resets to 0, and reads 0 in bits 31..3.
- R9: The capability register (offset 0x14) reads 0x0000_0400, with bit 10 meaning dual-role support. Writes to it and to the status register have no effect.
- R10: Reads from undecoded offsets (for example 0x18 or 0x20) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe; the write commits on the next rising edge |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| id_i | input | 1 | Connector ID level, asynchronous |
| bsess_i | input | 1 | B-session-valid level, asynchronous |
| peri_mode_o | output | 1 | Peripheral mode selected (control bit 6) |
| port_pwr_o | output | 1 | Port power request (control bit 5) |
| irq_o | output | 1 | Registered level interrupt |

## Verification
A fault in the synchronizer or edge detector appears as a status or event bit that changes one edge early or late. It can also appear as a missed falling-edge event, so the bench samples the status bit after edges one and two and the event bit after edges two and three. A corrupted event register shows at the next read as a bit that stays set after a clear, a bit that clears on a zero write, a clearable bit 31, or a set lost to a clear on the same edge. The collision case is forced on that exact edge. Interrupt faults appear as irq_o moving on the wrong edge or rising while the enable mask is zero. Both cases are checked within one or two cycles of the register write or event that causes them.

// File: rtl/otg_regs_pkg.sv
package otg_regs_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFS_CFG = 8'h00;
  localparam logic [7:0] OFS_CTL = 8'h04;
  localparam logic [7:0] OFS_EVT = 8'h08;
  localparam logic [7:0] OFS_EN  = 8'h0C;
  localparam logic [7:0] OFS_STS = 8'h10;
  localparam logic [7:0] OFS_HW  = 8'h14;

  localparam int EVT_ID_BIT   = 24;
  localparam int EVT_BSES_BIT = 8;
  localparam int EVT_MODE_BIT = 31;
  localparam int STS_ID_BIT   = 0;
  localparam int STS_BSES_BIT = 2;
  localparam int HW_OTG_BIT   = 10;

  localparam int CFG_W = 3;
  localparam int CTL_W = 7;
  localparam int CTL_PERI_BIT = 6;
  localparam int CTL_PWR_BIT  = 5;
  localparam logic [CTL_W-1:0] CTL_RST = 7'h40;

  // event slot indices inside the event unit
  localparam int NUM_EV  = 2;
  localparam int EV_ID   = 0;
  localparam int EV_BSES = 1;
endpackage

// File: rtl/otg_in_sync.sv
module otg_in_sync #(
  parameter int NUM_IN = 2,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] async_i,
  output logic [NUM_IN-1:0] sync_o,
  output logic [NUM_IN-1:0] chg_o
);
  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
      end else begin
        sh_q   <= {sh_q[STAGES-2:0], async_i[g]};
        prev_q <= sh_q[STAGES-1];
      end
    end

    assign sync_o[g] = sh_q[STAGES-1];
    assign chg_o[g]  = sh_q[STAGES-1] ^ prev_q;
  end
endmodule

// File: rtl/otg_evt_unit.sv
module otg_evt_unit #(
  parameter int NUM_EV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] set_i,
  input  logic              clr_we_i,
  input  logic [NUM_EV-1:0] clr_bits_i,
  input  logic              en_we_i,
  input  logic [NUM_EV-1:0] en_bits_i,
  output logic [NUM_EV-1:0] evt_o,
  output logic [NUM_EV-1:0] en_o,
  output logic              irq_o
);
  logic [NUM_EV-1:0] evt_q, en_q, clr;
  logic              irq_q;

  assign clr = clr_we_i ? clr_bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= (evt_q & ~clr) | set_i;  // set wins over clear
      if (en_we_i) en_q <= en_bits_i;
      irq_q <= |(evt_q & en_q);
    end
  end

  assign evt_o = evt_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_chk
    assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> evt_q[i]);
    assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[i] && !set_i[i]) |=> !evt_q[i]);
    assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr[i] && !set_i[i]) |=> $stable(evt_q[i]));
  end

  assert_irq_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> !irq_o);
  assert_irq_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(evt_q & en_q)));
endmodule

// File: rtl/otg_cfg_ctl.sv
module otg_cfg_ctl
  import otg_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             ctl_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [CTL_W-1:0] ctl_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ctl_q <= CTL_RST;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_wdata_i;
      if (ctl_we_i) ctl_q <= ctl_wdata_i;
    end
  end

  assign cfg_o = cfg_q;
  assign ctl_o = ctl_q;

  assert_ctl_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (ctl_o == $past(ctl_wdata_i)));
  assert_ctl_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(ctl_o));
  assert_cfg_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_o));
endmodule

// File: rtl/otg_regs.sv
module otg_regs
  import otg_regs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SYNC_ST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              id_i,
  input  logic              bsess_i,
  output logic              peri_mode_o,
  output logic              port_pwr_o,
  output logic              irq_o
);
  logic [NUM_EV-1:0] sync_lvl, chg, evt, en, clr_bits, en_bits;
  logic [CFG_W-1:0]  cfg;
  logic [CTL_W-1:0]  ctl;
  logic              sel_cfg, sel_ctl, sel_evt, sel_en;
  logic              wdata_unused;

  assign sel_cfg = addr_i == ADDR_W'(OFS_CFG);
  assign sel_ctl = addr_i == ADDR_W'(OFS_CTL);
  assign sel_evt = addr_i == ADDR_W'(OFS_EVT);
  assign sel_en  = addr_i == ADDR_W'(OFS_EN);

  always_comb begin
    clr_bits          = '0;
    en_bits           = '0;
    clr_bits[EV_ID]   = wdata_i[EVT_ID_BIT];
    clr_bits[EV_BSES] = wdata_i[EVT_BSES_BIT];
    en_bits[EV_ID]    = wdata_i[EVT_ID_BIT];
    en_bits[EV_BSES]  = wdata_i[EVT_BSES_BIT];
  end

  assign wdata_unused = ^wdata_i;

  otg_in_sync #(.NUM_IN(NUM_EV), .STAGES(SYNC_ST)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({bsess_i, id_i}),
    .sync_o  (sync_lvl),
    .chg_o   (chg)
  );

  otg_evt_unit #(.NUM_EV(NUM_EV)) i_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (chg),
    .clr_we_i   (we_i && sel_evt),
    .clr_bits_i (clr_bits),
    .en_we_i    (we_i && sel_en),
    .en_bits_i  (en_bits),
    .evt_o      (evt),
    .en_o       (en),
    .irq_o      (irq_o)
  );

  otg_cfg_ctl i_cfg_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (we_i && sel_cfg),
    .ctl_we_i    (we_i && sel_ctl),
    .cfg_wdata_i (wdata_i[CFG_W-1:0]),
    .ctl_wdata_i (wdata_i[CTL_W-1:0]),
    .cfg_o       (cfg),
    .ctl_o       (ctl)
  );

  assign peri_mode_o = ctl[CTL_PERI_BIT];
  assign port_pwr_o  = ctl[CTL_PWR_BIT];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFS_CFG): rdata_o[CFG_W-1:0] = cfg;
      ADDR_W'(OFS_CTL): rdata_o[CTL_W-1:0] = ctl;
      ADDR_W'(OFS_EVT): begin
        rdata_o[EVT_ID_BIT]   = evt[EV_ID];
        rdata_o[EVT_BSES_BIT] = evt[EV_BSES];
        rdata_o[EVT_MODE_BIT] = ctl[CTL_PERI_BIT];
      end
      ADDR_W'(OFS_EN): begin
        rdata_o[EVT_ID_BIT]   = en[EV_ID];
        rdata_o[EVT_BSES_BIT] = en[EV_BSES];
      end
      ADDR_W'(OFS_STS): begin
        rdata_o[STS_ID_BIT]   = sync_lvl[EV_ID];
        rdata_o[STS_BSES_BIT] = sync_lvl[EV_BSES];
      end
      ADDR_W'(OFS_HW): rdata_o[HW_OTG_BIT] = 1'b1;
      default: rdata_o = '0;
    endcase
  end

  assert_id_evt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_lvl[EV_ID] != $past(sync_lvl[EV_ID])) |=> evt[EV_ID]);
  assert_bses_evt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_lvl[EV_BSES] != $past(sync_lvl[EV_BSES])) |=> evt[EV_BSES]);
  assert_mode_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_evt |-> (rdata_o[EVT_MODE_BIT] == peri_mode_o));
  assert_hw_ro_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_HW)) |-> (rdata_o == 32'h0000_0400));
endmodule

// File: tb/test_otg_regs.sv
module test_otg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        id = 1'b0, bsess = 1'b0;
  logic        peri, pwr, irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  otg_regs i_otg_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .id_i(id), .bsess_i(bsess), .peri_mode_o(peri),
    .port_pwr_o(pwr), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // sample in the current low phase
  task automatic peek(logic [7:0] a, logic [31:0] exp, string tag);
    addr = a; #1; chk(tag, rdata, exp);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); peek(a, exp, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic t_reset;
    rd(8'h00, 32'h0, "R8 cfg reset");
    rd(8'h04, 32'h40, "R7 ctl reset");
    rd(8'h08, 32'h8000_0000, "R4 evt reset mode flag");
    rd(8'h0C, 32'h0, "R6 en reset");
    rd(8'h10, 32'h0, "R1 sts reset");
    rd(8'h14, 32'h400, "R9 hw param");
    rd(8'h18, 32'h0, "R10 undecoded 0x18");
    rd(8'h20, 32'h0, "R10 undecoded 0x20");
    chk("R7 peri reset", {31'b0, peri}, 1);
    chk("R7 pwr reset", {31'b0, pwr}, 0);
    chk("R6 irq reset", {31'b0, irq}, 0);
  endtask

  task automatic t_id;
    @(negedge clk); id = 1'b1;
    @(posedge clk); @(negedge clk);
    peek(8'h10, 32'h0, "R1 sts not after edge1");
    @(posedge clk); @(negedge clk);
    peek(8'h10, 32'h1, "R1 sts id after edge2");
    peek(8'h08, 32'h8000_0000, "R2 evt not after edge2");
    @(posedge clk); @(negedge clk);
    peek(8'h08, 32'h8100_0000, "R2 id rise event");
    wr(8'h08, 32'h0100_0000);
    rd(8'h08, 32'h8000_0000, "R4 w1c id");
    @(negedge clk); id = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    peek(8'h08, 32'h8100_0000, "R2 id fall event");
    peek(8'h10, 32'h0, "R1 sts id low");
    wr(8'h08, 32'h0100_0000);
  endtask

  task automatic t_bsess;
    @(negedge clk); bsess = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    peek(8'h08, 32'h8000_0100, "R3 bsess rise event");
    peek(8'h10, 32'h4, "R1 sts bsess");
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h8000_0100, "R4 zero write keeps");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h8000_0000, "R4 clear all keeps bit31");
  endtask

  task automatic t_irq;
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0100_0100, "R6 en writable bits");
    @(negedge clk); bsess = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 irq not yet", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R6 irq raised", {31'b0, irq}, 1);
    wr(8'h08, 32'h0000_0100);
    @(negedge clk);
    chk("R6 irq dropped", {31'b0, irq}, 0);
    wr(8'h0C, 32'h0);
    @(negedge clk); id = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 masked irq", {31'b0, irq}, 0);
    peek(8'h08, 32'h8100_0000, "R2 masked event latched");
    wr(8'h0C, 32'h0100_0000);
    chk("R6 irq one edge after enable", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R6 irq after enable", {31'b0, irq}, 1);
    wr(8'h0C, 32'h0);
  endtask

  task automatic t_collision;
    // bit24 pending; new ID edge sets on the same edge that a clear commits
    @(negedge clk); id = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 8'h08; wdata = 32'h0100_0000; we = 1'b1;
    @(negedge clk); we = 1'b0;
    peek(8'h08, 32'h8100_0000, "R5 set wins over clear");
    wr(8'h08, 32'h0100_0000);
    rd(8'h08, 32'h8000_0000, "R4 clear after collision");
  endtask

  task automatic t_ctl_cfg;
    wr(8'h04, 32'h20);
    chk("R7 peri off", {31'b0, peri}, 0);
    chk("R7 pwr on", {31'b0, pwr}, 1);
    rd(8'h04, 32'h20, "R7 ctl readback");
    rd(8'h08, 32'h0, "R4 bit31 follows mode");
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h7F, "R7 ctl width");
    wr(8'h04, 32'h40);
    rd(8'h08, 32'h8000_0000, "R4 bit31 back");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h7, "R8 cfg width");
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R8 cfg clear");
  endtask

  task automatic t_ro;
    wr(8'h14, 32'h0);
    rd(8'h14, 32'h400, "R9 hw write ignored");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R9 sts write ignored");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0, "R10 undecoded write cfg");
    rd(8'h04, 32'h40, "R10 undecoded write ctl");
    rd(8'h0C, 32'h0, "R10 undecoded write en");
    rd(8'h18, 32'h0, "R10 undecoded read");
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_id();
    t_bsess();
    t_irq();
    t_collision();
    t_ctl_cfg();
    t_ro();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule